// File: doc/BRIEF.md
# Multiprocessor-Capable Async Serial Receiver

This block recovers characters from an asynchronous serial line using a clock-enable strobe that arrives sixteen times per bit period. Character length, parity and multiprocessor address filtering are chosen by static control inputs. Each character is placed, together with its own error flags, into a small receive queue. Software reads the oldest character by pulsing a read strobe.

In multiprocessor mode, only 9-bit frames whose top data bit is one are kept. These are the address frames. All other frames are thrown away, and a one-cycle strobe marks each accepted address frame. Dropping the receiver enable abandons any frame in progress and empties the queue at once.

Top module: `serial_rx_mp`

## Requirements
- R1: The idle line is high. A frame is a low start bit, then `char_len` data bits least significant first, then an optional parity bit, then a high stop bit. `char_len` values below 5 act as 5 and values above 9 act as 9. The data appears right-aligned on `rx_data`, and bits above the length read 0. `rx_bit8` carries the ninth data bit and is 0 unless the length is 9.
- R2: The line passes through a two-flop synchroniser. A bit spans 16 `tick` strobes. The tick on which the synchronised line is first seen low while idle is sample 0 of the start bit. Every bit, the start bit included, takes the majority of its samples 7, 8 and 9. A start bit whose majority is high is a false start: the receiver returns to idle and stores nothing.
- R3: `par_mode` 2'b10 selects even parity, 2'b11 selects odd parity, and 2'b0x selects no parity bit. The expected parity bit is the XOR of the data bits, inverted for odd parity. A mismatch sets `rx_pe` for that character only. `rx_pe` is 0 when parity is off.
- R4: Only the first stop bit is examined. A low majority there sets `rx_fe`, and the character is still stored. The receiver is idle again from sample 9 of the first stop bit, so a second stop bit is never checked and a new start bit may follow directly.
- R5: While `mp_mode` is 1, a frame whose ninth data bit is 0 is discarded. It is not stored, it does not raise `rx_ready`, and it does not cause an overrun. Frames whose ninth bit is 1 are stored normally. With `mp_mode` at 0, every frame is stored.
- R6: `addr_stb` is high for exactly one cycle for each frame completed in multiprocessor mode with its ninth bit set. It rises in the same cycle that the character becomes visible.
- R7: The queue holds `DEPTH` (2) characters, each with its ninth bit and its FE, PE and overrun flags. `rx_ready` is high while at least one unread character is held. The outputs show the oldest character, and all outputs read 0 when the queue is empty. A `rd` pulse while `rx_ready` is high removes the oldest character at that clock edge.
- R8: A character that completes while the queue is full, with no read at the same edge, is lost. In that case `rx_ovr` is set on the newest stored entry.
- R9: While `rx_en` is 0, any frame in progress is abandoned and nothing is received. The queue is emptied at the first clock edge with `rx_en` low, so `rx_ready` is 0 in the next cycle.
- R10: A character, its flags and `rx_ready` appear one clock after the edge at which the tick holding sample 9 of the first stop bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| rx_en | input | 1 | Receiver enable; low flushes the queue |
| serial_in | input | 1 | Asynchronous serial line |
| char_len | input | 4 | Data bits per frame, 5 to 9 |
| par_mode | input | 2 | Parity select: 0x none, 10 even, 11 odd |
| mp_mode | input | 1 | Multiprocessor address filter on |
| rd | input | 1 | Read strobe: removes the oldest character |
| rx_data | output | 8 | Data bits 7..0 of the oldest character |
| rx_bit8 | output | 1 | Ninth data bit of the oldest character |
| rx_fe | output | 1 | Frame error of the oldest character |
| rx_pe | output | 1 | Parity error of the oldest character |
| rx_ovr | output | 1 | A character was lost after this one |
| rx_ready | output | 1 | At least one unread character |
| addr_stb | output | 1 | One-cycle mark of an accepted address frame |

## Verification
The line is seen two clocks late because of the synchroniser. A stored character, its flags, `rx_ready` and `addr_stb` are all due one clock after the edge that takes the stop bit's ninth sample. A flush shows one clock after `rx_en` falls, and a read takes effect at the next edge. The bench drives its inputs on falling edges and updates its reference model on rising edges. It compares every output on each falling edge, so each result is checked in exactly the cycle it is due. Directed checks on decoded values, error flags, address filtering, overrun order and flushing are made after the line has idled for at least one bit past the stop sample.

// File: rtl/serial_rx_mp.sv
module serial_rx_mp #(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       serial_in,
  input  logic [3:0] char_len,
  input  logic [1:0] par_mode,
  input  logic       mp_mode,
  input  logic       rd,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_fe,
  output logic       rx_pe,
  output logic       rx_ovr,
  output logic       rx_ready,
  output logic       addr_stb
);
  localparam int CW = $clog2(OSR);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 12;
  localparam logic [CW-1:0] VOTE_AT = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);
  localparam logic [PW:0]   FULLC   = (PW + 1)'(DEPTH);
  localparam logic [PW-1:0] TOP     = PW'(DEPTH - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PARB, STOP} st_t;

  logic          s1, s2;
  logic [1:0]    smp;
  st_t           st;
  logic [CW-1:0] sc;
  logic [3:0]    bi;
  logic [8:0]    dat;
  logic          pbit;
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  wire [3:0]    nbits   = (char_len < 4'd5) ? 4'd5 : (char_len > 4'd9) ? 4'd9 : char_len;
  wire          par_en  = par_mode[1];
  wire          vote    = (smp[1] & smp[0]) | (smp[1] & s2) | (smp[0] & s2);
  wire          at_vote = tick && (sc == VOTE_AT);
  wire          at_end  = tick && (sc == LAST);
  wire          done    = rx_en && (st == STOP) && at_vote;
  wire          accept  = !(mp_mode && !dat[8]);
  wire          par_bad = par_en && (pbit != (^dat ^ par_mode[0]));
  wire          push    = done && accept;
  wire          pop     = rx_en && rd && (cnt != '0);
  wire          full    = (cnt == FULLC);
  wire          wr      = push && (!full || pop);
  wire [PW-1:0] newest  = (wp == '0) ? TOP : wp - 1'b1;
  wire [EW-1:0] head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= serial_in;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp <= 2'b11;
    else if (tick) smp <= {smp[0], s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= IDLE;
      sc   <= '0;
      bi   <= '0;
      dat  <= '0;
      pbit <= 1'b0;
    end else if (!rx_en) begin
      st <= IDLE;
    end else if (tick) begin
      if (st == IDLE) begin
        if (!s2) begin
          st  <= START;
          sc  <= CW'(1);
          dat <= '0;
        end
      end else begin
        sc <= (sc == LAST) ? '0 : sc + 1'b1;
        case (st)
          START:
            if (at_vote && vote) st <= IDLE;
            else if (at_end) begin
              st <= DATA;
              bi <= '0;
            end
          DATA: begin
            if (at_vote) dat[bi] <= vote;
            if (at_end) begin
              if (bi == nbits - 4'd1) st <= par_en ? PARB : STOP;
              else bi <= bi + 4'd1;
            end
          end
          PARB: begin
            if (at_vote) pbit <= vote;
            if (at_end) st <= STOP;
          end
          STOP:    if (at_vote) st <= IDLE;
          default: st <= IDLE;
        endcase
      end
    end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {1'b0, !vote, par_bad, dat};
    else if (push && rx_en) mem[newest][EW-1] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (!rx_en) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (pop) rp <= nxt(rp);
      if (wr)  wp <= nxt(wp);
      cnt <= cnt + {{PW{1'b0}}, wr} - {{PW{1'b0}}, pop};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_stb <= 1'b0;
    else        addr_stb <= done && mp_mode && dat[8];

  assign rx_ready = (cnt != '0);
  assign rx_data  = rx_ready ? head[7:0] : 8'h00;
  assign rx_bit8  = rx_ready & head[8];
  assign rx_pe    = rx_ready & head[9];
  assign rx_fe    = rx_ready & head[10];
  assign rx_ovr   = rx_ready & head[11];

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready);

  assert_addr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> !addr_stb);

  assert_addr_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |-> ($past(mp_mode) && rx_bit8 == rx_ready));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);

  assert_ready_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(done));

  assert_drop_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_mode && !dat[8] && !rd) |=> $stable(cnt));
endmodule

// File: tb/tb_serial_rx_mp.sv
module tb_serial_rx_mp;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_en = 1'b0;
  logic       serial_in = 1'b1, mp_mode = 1'b0, rd = 1'b0;
  logic [3:0] char_len = 4'd8;
  logic [1:0] par_mode = 2'b00;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_fe, rx_pe, rx_ovr, rx_ready, addr_stb;

  int total = 0, bad = 0, addr_seen = 0, tphase = 0;

  always #2 clk = ~clk;

  serial_rx_mp dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .serial_in(serial_in),
    .char_len(char_len), .par_mode(par_mode), .mp_mode(mp_mode), .rd(rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_fe(rx_fe), .rx_pe(rx_pe),
    .rx_ovr(rx_ovr), .rx_ready(rx_ready), .addr_stb(addr_stb));

  // reference model state
  int        m_ph = 0, m_sc = 0, m_bi = 0;
  bit        m_s1 = 1'b1, m_s2 = 1'b1, m_h7 = 1'b1, m_h8 = 1'b1, m_pb = 1'b0, m_addr = 1'b0;
  bit [8:0]  m_dat = '0;
  bit [11:0] q[$];

  always @(posedge clk) begin
    bit ln, v, vt, en;
    bit [11:0] e;
    int n;
    if (!rst_n) begin
      m_ph = 0; q.delete(); m_addr = 0; m_s1 = 1; m_s2 = 1; m_h7 = 1; m_h8 = 1;
    end else begin
      ln = m_s2; m_s2 = m_s1; m_s1 = serial_in;
      m_addr = 0;
      n = (char_len < 5) ? 5 : (char_len > 9) ? 9 : int'(char_len);
      v = (m_h7 & m_h8) | (m_h7 & ln) | (m_h8 & ln);
      if (!rx_en) begin
        m_ph = 0; q.delete();
      end else begin
        if (rd && q.size() > 0) void'(q.pop_front());
        if (tick) begin
          if (m_ph == 0) begin
            if (!ln) begin m_ph = 1; m_sc = 1; m_dat = '0; end
          end else begin
            vt = (m_sc == 9); en = (m_sc == 15);
            case (m_ph)
              1: if (vt && v) m_ph = 0; else if (en) begin m_ph = 2; m_bi = 0; end
              2: begin
                if (vt) m_dat[m_bi] = v;
                if (en) begin
                  if (m_bi == n - 1) m_ph = par_mode[1] ? 3 : 4;
                  else m_bi++;
                end
              end
              3: begin if (vt) m_pb = v; if (en) m_ph = 4; end
              default: if (vt) begin
                m_ph = 0;
                if (!(mp_mode && !m_dat[8])) begin
                  e = {1'b0, !v, par_mode[1] && (m_pb != (^m_dat ^ par_mode[0])), m_dat};
                  if (q.size() == 2) begin
                    e = q[q.size()-1]; e[11] = 1'b1; q[q.size()-1] = e;
                  end else q.push_back(e);
                end
                m_addr = mp_mode && m_dat[8];
              end
            endcase
            m_sc = (m_sc + 1) % 16;
          end
        end
      end
      if (tick) begin m_h7 = m_h8; m_h8 = ln; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit [11:0] h;
    @(negedge clk);
    h = (q.size() > 0) ? q[0] : 12'h0;
    chk("R10 per-cycle outputs", {q.size() > 0, h[8], h[10], h[9], h[11], h[7:0], m_addr},
        {rx_ready, rx_bit8, rx_fe, rx_pe, rx_ovr, rx_data, addr_stb});
    if (addr_stb) addr_seen++;
    tphase = (tphase + 1) % 4;
    tick = (tphase == 0);
  endtask

  task automatic hold(input bit val, input int nclk);
    serial_in = val;
    repeat (nclk) step();
  endtask

  task automatic send(input bit [8:0] d, input int n, input bit badpar, input bit stopv, input int idle);
    bit [8:0] dm;
    dm = d & ((9'h1 << n) - 9'h1);
    hold(1'b0, 64);
    for (int i = 0; i < n; i++) hold(d[i], 64);
    if (par_mode[1]) hold((^dm) ^ par_mode[0] ^ badpar, 64);
    hold(stopv, 64);
    hold(1'b1, 64 * idle);
  endtask

  task automatic expect_char(input string tag, input bit [8:0] d, input int n,
                             input bit pe, input bit fe, input bit ovr);
    bit [8:0] dm;
    dm = d & ((9'h1 << n) - 9'h1);
    chk({tag, " R7 ready"}, rx_ready, 1);
    chk({tag, " data"}, rx_data, dm[7:0]);
    chk({tag, " bit8"}, rx_bit8, dm[8]);
    chk({tag, " R3 pe"}, rx_pe, pe);
    chk({tag, " R4 fe"}, rx_fe, fe);
    chk({tag, " R8 ovr"}, rx_ovr, ovr);
    rd = 1'b1;
    step();
    rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) step();
    rst_n = 1'b1; rx_en = 1'b1;
    repeat (4) step();
    chk("R7 reset ready", rx_ready, 0);
    chk("R7 reset data", rx_data, 0);
    hold(1'b1, 128);

    send(9'h0A5, 8, 0, 1, 2);   expect_char("R1 8N1", 9'h0A5, 8, 0, 0, 0);
    char_len = 4'd5;
    send(9'h0F6, 5, 0, 1, 2);   expect_char("R1 5-bit", 9'h0F6, 5, 0, 0, 0);
    char_len = 4'd2;
    send(9'h00B, 5, 0, 1, 2);   expect_char("R1 clamp", 9'h00B, 5, 0, 0, 0);
    char_len = 4'd9; par_mode = 2'b10;
    send(9'h1C3, 9, 0, 1, 2);   expect_char("R1 R3 9-bit even", 9'h1C3, 9, 0, 0, 0);
    char_len = 4'd8; par_mode = 2'b11;
    send(9'h03C, 8, 1, 1, 2);   expect_char("R3 odd bad", 9'h03C, 8, 1, 0, 0);
    send(9'h03D, 8, 0, 1, 2);   expect_char("R3 odd good", 9'h03D, 8, 0, 0, 0);
    par_mode = 2'b00;
    send(9'h055, 8, 0, 0, 2);   expect_char("R4 stop low", 9'h055, 8, 0, 1, 0);
    send(9'h012, 8, 0, 1, 0);
    send(9'h034, 8, 0, 1, 2);
    expect_char("R4 back-to-back a", 9'h012, 8, 0, 0, 0);
    expect_char("R4 back-to-back b", 9'h034, 8, 0, 0, 0);

    hold(1'b0, 16); hold(1'b1, 64 * 3);
    chk("R2 false start", rx_ready, 0);

    mp_mode = 1'b1; char_len = 4'd9; addr_seen = 0;
    send(9'h077, 9, 0, 1, 2);
    chk("R5 data frame dropped", rx_ready, 0);
    chk("R6 no strobe on data frame", addr_seen, 0);
    send(9'h1A0, 9, 0, 1, 2);
    chk("R6 one strobe on address", addr_seen, 1);
    expect_char("R5 address kept", 9'h1A0, 9, 0, 0, 0);
    mp_mode = 1'b0;
    send(9'h077, 9, 0, 1, 2);   expect_char("R5 filter off", 9'h077, 9, 0, 0, 0);

    char_len = 4'd8;
    send(9'h001, 8, 0, 1, 1);
    send(9'h002, 8, 0, 1, 1);
    send(9'h003, 8, 0, 1, 1);
    expect_char("R8 first", 9'h001, 8, 0, 0, 0);
    expect_char("R8 newest flagged", 9'h002, 8, 0, 0, 1);
    chk("R8 lost char", rx_ready, 0);

    send(9'h044, 8, 0, 1, 1);
    send(9'h045, 8, 0, 1, 1);
    chk("R9 before flush", rx_ready, 1);
    rx_en = 1'b0; step();
    chk("R9 flushed", rx_ready, 0);
    rx_en = 1'b1; step(); step();
    chk("R9 stays empty", rx_ready, 0);

    hold(1'b0, 64); hold(1'b1, 64); hold(1'b0, 32);
    rx_en = 1'b0;
    hold(1'b0, 64 * 3); hold(1'b1, 64 * 6);
    rx_en = 1'b1;
    hold(1'b1, 128);
    chk("R9 abandoned frame", rx_ready, 0);
    send(9'h09C, 8, 0, 1, 2);   expect_char("R9 after re-enable", 9'h09C, 8, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule